// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings an SDRAM device from power-on into a usable state. On a start pulse it latches its configuration, optionally waits a programmable number of clock cycles so the memory sees its required power-on idle time, and then drives a fixed command series onto the SDRAM command pins. The series is one all-bank precharge, then eight auto-refresh commands, then one mode-register-set. Programmable idle gaps separate the commands, and a final idle cycle follows the mode-register-set.

The mode word carried on the address pins during the mode-register-set encodes burst length 1, the CAS latency (2 or 3) and the write burst mode (single write or burst write). It is shifted into place according to whether the data bus is 16 or 32 bits wide. A controller asserts start once after reset and waits for the done pulse before normal accesses begin. While the sequence runs, busy is high and further start pulses have no effect.

Top module: `sdram_init_seq`

## Requirements
- R1: After a start is accepted, the only commands issued are, in order, one all-bank precharge, exactly eight auto-refresh commands and one mode-register-set.
- R2: Between the precharge and the first refresh there are exactly trp_wait_i+1 NOP cycles (1 to 4).
- R3: Between consecutive refreshes, and between the eighth refresh and the mode-register-set, there are exactly trc_wait_i+1 NOP cycles (1 to 4).
- R4: The mode-register-set is followed by exactly one NOP cycle with busy still high. In the next cycle busy is low and done_o is high for exactly one clock.
- R5: With pwr_wait_i = N > 0, the first N busy cycles are NOP and the precharge comes in busy cycle N+1. With N = 0 the precharge comes in the first busy cycle. Busy rises in the cycle after the clock edge that samples start.
- R6: During mode-register-set the address bus carries, for {32-bit bus, write mode, CAS latency}: 16-bit single write 0x440 (CL2) and 0x460 (CL3); 16-bit burst write 0x040 and 0x060; 32-bit single write 0x880 and 0x8C0; 32-bit burst write 0x080 and 0x0C0. The inputs are bus32_i=1 for a 32-bit bus, burst_wr_i=1 for burst write and cas_lat3_i=1 for CAS latency 3.
- R7: Command pins {cs_n,ras_n,cas_n,we_n} read 0111 for NOP, 0010 for precharge (with address bit 10 high and all other address bits low), 0001 for refresh and 0000 for mode-register-set. The address is zero on NOP and refresh cycles.
- R8: Out of reset and whenever busy is low the pins read deselect (1111) with a zero address, busy and done low. While busy is high, chip select is low.
- R9: A start pulse while busy is ignored. The configuration latched at the accepted start governs the whole sequence, whatever the inputs do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin the initialization sequence (accepted only when idle) |
| trp_wait_i | input | 2 | Precharge-to-refresh gap; NOP count is value+1 |
| trc_wait_i | input | 2 | Refresh-to-refresh and refresh-to-mode gap; NOP count is value+1 |
| cas_lat3_i | input | 1 | 1 selects CAS latency 3, 0 selects CAS latency 2 |
| bus32_i | input | 1 | 1 for a 32-bit data bus, 0 for 16-bit |
| burst_wr_i | input | 1 | 1 for burst write, 0 for single write |
| pwr_wait_i | input | 16 | Power-on idle cycles before precharge; 0 skips the wait |
| sd_cs_n_o | output | 1 | SDRAM chip select, active low |
| sd_ras_n_o | output | 1 | SDRAM row address strobe, active low |
| sd_cas_n_o | output | 1 | SDRAM column address strobe, active low |
| sd_we_n_o | output | 1 | SDRAM write enable, active low |
| sd_addr_o | output | 13 | SDRAM address bus |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the sequence has completed |

## Verification
The bench predicts every pin in every cycle of a sequence from the gap and wait settings. It targets the extreme gaps (0 and 3) and power-on waits of 0 and 1, where an off-by-one counter would add or drop a NOP or issue the precharge one cycle late. All eight mode-word combinations are driven, because a wrong shift for bus width or a swapped write-mode bit shows up only on the address pins during the mode-register-set. In one run start is pulsed again in mid-sequence with different settings. A design that restarted or sampled the configuration live would then show a disturbed command series or a wrong mode word.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWR,
    ST_PALL,
    ST_TRP,
    ST_REF,
    ST_TRC,
    ST_MRS,
    ST_POST
  } init_st_e;

  // Mode word: burst length 1, CAS latency in bits 6:4, single-write flag
  // in bit 9, then shifted by the byte-lane offset of the data bus.
  function automatic logic [15:0] mode_word(input logic cl3, input logic bus32,
                                            input logic burst_wr);
    logic [15:0] raw;
    raw = 16'h0000;
    raw[6:4] = cl3 ? 3'd3 : 3'd2;
    raw[9]   = ~burst_wr;
    return bus32 ? (raw << 2) : (raw << 1);
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             dec,
  output logic             zero
);
  logic [WIDTH-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (dec && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load || dec) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_cmdenc.sv
module sdram_init_cmdenc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  init_st_e          state,
  input  logic              cl3,
  input  logic              bus32,
  input  logic              burst_wr,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr
);
  localparam int PALL_BIT = 10;
  logic [15:0] mword;

  assign mword = mode_word(cl3, bus32, burst_wr);

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    addr = '0;
    unique case (state)
      ST_IDLE: {cs_n, ras_n, cas_n, we_n} = 4'b1111;
      ST_PALL: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0010;
        addr[PALL_BIT] = 1'b1;
      end
      ST_REF:  {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      ST_MRS: begin
        {cs_n, ras_n, cas_n, we_n} = 4'b0000;
        addr = mword[ADDR_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int PWR_W   = 16,
  parameter int NUM_REF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        trp_wait_i,
  input  logic [1:0]        trc_wait_i,
  input  logic              cas_lat3_i,
  input  logic              bus32_i,
  input  logic              burst_wr_i,
  input  logic [PWR_W-1:0]  pwr_wait_i,
  output logic              sd_cs_n_o,
  output logic              sd_ras_n_o,
  output logic              sd_cas_n_o,
  output logic              sd_we_n_o,
  output logic [ADDR_W-1:0] sd_addr_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int REF_W = $clog2(NUM_REF + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  init_st_e         st_q, st_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic             done_q, done_d;
  logic [1:0]       trp_q, trc_q;
  logic             cl3_q, bus32_q, bwr_q;
  logic             accept;
  logic             t_load, t_dec, t_zero;
  logic [PWR_W-1:0] t_val;

  assign accept = (st_q == ST_IDLE) && start_i;

  always_comb begin
    st_d   = st_q;
    ref_d  = ref_q;
    done_d = 1'b0;
    t_load = 1'b0;
    t_dec  = 1'b0;
    t_val  = '0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        if (pwr_wait_i == '0) begin
          st_d = ST_PALL;
        end else begin
          st_d   = ST_PWR;
          t_load = 1'b1;
          t_val  = pwr_wait_i - 1'b1;
        end
      end
      ST_PWR: begin
        t_dec = 1'b1;
        if (t_zero) st_d = ST_PALL;
      end
      ST_PALL: begin
        st_d   = ST_TRP;
        ref_d  = '0;
        t_load = 1'b1;
        t_val  = {{(PWR_W-2){1'b0}}, trp_q};
      end
      ST_TRP: begin
        t_dec = 1'b1;
        if (t_zero) st_d = ST_REF;
      end
      ST_REF: begin
        st_d   = ST_TRC;
        ref_d  = ref_q + 1'b1;
        t_load = 1'b1;
        t_val  = {{(PWR_W-2){1'b0}}, trc_q};
      end
      ST_TRC: begin
        t_dec = 1'b1;
        if (t_zero) st_d = (ref_q == REF_W'(NUM_REF)) ? ST_MRS : ST_REF;
      end
      ST_MRS:  st_d = ST_POST;
      ST_POST: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= ST_IDLE;
      ref_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ref_q  <= ref_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      trp_q   <= '0;
      trc_q   <= '0;
      cl3_q   <= 1'b0;
      bus32_q <= 1'b0;
      bwr_q   <= 1'b0;
    end else if (accept) begin
      trp_q   <= trp_wait_i;
      trc_q   <= trc_wait_i;
      cl3_q   <= cas_lat3_i;
      bus32_q <= bus32_i;
      bwr_q   <= burst_wr_i;
    end
  end

  sdram_init_timer #(.WIDTH(PWR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (t_load),
    .load_val (t_val),
    .dec      (t_dec),
    .zero     (t_zero)
  );

  sdram_init_cmdenc #(.ADDR_W(ADDR_W)) u_enc (
    .state    (st_q),
    .cl3      (cl3_q),
    .bus32    (bus32_q),
    .burst_wr (bwr_q),
    .cs_n     (sd_cs_n_o),
    .ras_n    (sd_ras_n_o),
    .cas_n    (sd_cas_n_o),
    .we_n     (sd_we_n_o),
    .addr     (sd_addr_o)
  );

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int NUM_REF = 8
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic busy,
  input logic done
);
  logic [3:0] cmd;
  logic       is_pall, is_ref, is_mrs, is_nop;
  logic       pall_seen_q;
  logic [4:0] ref_seen_q;

  assign cmd     = {cs_n, ras_n, cas_n, we_n};
  assign is_pall = (cmd == 4'b0010);
  assign is_ref  = (cmd == 4'b0001);
  assign is_mrs  = (cmd == 4'b0000);
  assign is_nop  = (cmd == 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pall_seen_q <= 1'b0;
      ref_seen_q  <= '0;
    end else if (is_pall) begin
      pall_seen_q <= 1'b1;
      ref_seen_q  <= '0;
    end else if (done) begin
      pall_seen_q <= 1'b0;
    end else if (is_ref && ref_seen_q != 5'd31) begin
      ref_seen_q <= ref_seen_q + 1'b1;
    end
  end

  p_ref_after_pall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> pall_seen_q && (ref_seen_q < 5'(NUM_REF)));
  p_mrs_after_refs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |-> pall_seen_q && (ref_seen_q == 5'(NUM_REF)));
  p_ref_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |=> is_nop);
  p_post_mrs_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |=> is_nop && busy);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_at_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !busy && $past(busy));
  p_pall_a10_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_pall |-> a10);
  p_select_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy != cs_n);
endmodule

bind sdram_init_seq sdram_init_chk #(.NUM_REF(NUM_REF)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cs_n  (sd_cs_n_o),
  .ras_n (sd_ras_n_o),
  .cas_n (sd_cas_n_o),
  .we_n  (sd_we_n_o),
  .a10   (sd_addr_o[10]),
  .busy  (busy_o),
  .done  (done_o)
);

// File: tb/test_sdram_init_seq.sv
`timescale 1ns/1ps
module test_sdram_init_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  trp_wait_i, trc_wait_i;
  logic        cas_lat3_i, bus32_i, burst_wr_i;
  logic [15:0] pwr_wait_i;
  logic        sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o;
  logic [12:0] sd_addr_o;
  logic        busy_o, done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  sdram_init_seq i_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .trp_wait_i(trp_wait_i), .trc_wait_i(trc_wait_i),
    .cas_lat3_i(cas_lat3_i), .bus32_i(bus32_i), .burst_wr_i(burst_wr_i),
    .pwr_wait_i(pwr_wait_i),
    .sd_cs_n_o(sd_cs_n_o), .sd_ras_n_o(sd_ras_n_o), .sd_cas_n_o(sd_cas_n_o),
    .sd_we_n_o(sd_we_n_o), .sd_addr_o(sd_addr_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  localparam logic [3:0] C_DESEL = 4'b1111, C_NOP = 4'b0111,
                         C_PALL = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  // R6 values as listed in the requirement
  function automatic logic [12:0] exp_mode(bit b32, bit bwr, bit cl3);
    case ({b32, bwr, cl3})
      3'b000:  return 13'h440;
      3'b001:  return 13'h460;
      3'b010:  return 13'h040;
      3'b011:  return 13'h060;
      3'b100:  return 13'h880;
      3'b101:  return 13'h8C0;
      3'b110:  return 13'h080;
      default: return 13'h0C0;
    endcase
  endfunction

  task automatic check(string req, int k, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %h expected %h", req, k, act, exp);
    end
  endtask

  // one accepted start; optionally a second start at busy cycle ign_k
  task automatic run_seq(int n, int trp, int trc, bit b32, bit bwr, bit cl3, int ign_k);
    int pall_k, ref0, mrs_k, last_k;
    pall_k = n + 1;
    ref0   = pall_k + trp + 2;
    mrs_k  = ref0 + 8 * (trc + 2);
    last_k = mrs_k + 3;
    @(negedge clk);
    pwr_wait_i = 16'(n); trp_wait_i = 2'(trp); trc_wait_i = 2'(trc);
    bus32_i = b32; burst_wr_i = bwr; cas_lat3_i = cl3;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 1; k <= last_k; k++) begin
      logic [3:0]  ec;
      logic [12:0] ea;
      logic        eb, ed;
      string       rq;
      ea = '0; eb = 1'b1; ed = 1'b0;
      if (k <= n)                  begin ec = C_NOP;  rq = "R5"; end
      else if (k == pall_k)        begin ec = C_PALL; ea = 13'h400; rq = "R7"; end
      else if (k < ref0)           begin ec = C_NOP;  rq = "R2"; end
      else if (k < mrs_k)          begin
        ec = (((k - ref0) % (trc + 2)) == 0) ? C_REF : C_NOP; rq = "R3";
      end
      else if (k == mrs_k)         begin ec = C_MRS; ea = exp_mode(b32, bwr, cl3); rq = "R6"; end
      else if (k == mrs_k + 1)     begin ec = C_NOP; rq = "R4"; end
      else if (k == mrs_k + 2)     begin ec = C_DESEL; eb = 1'b0; ed = 1'b1; rq = "R4"; end
      else                         begin ec = C_DESEL; eb = 1'b0; rq = "R8"; end
      // R1 order and R9 latching are covered by every per-cycle compare
      check(rq, k, {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o, sd_addr_o, busy_o, done_o},
            {ec, ea, eb, ed});
      if (k == ign_k) begin
        // R9: disturbing start with different settings
        pwr_wait_i = 16'd7; trp_wait_i = 2'(~trp); trc_wait_i = 2'(~trc);
        bus32_i = ~b32; burst_wr_i = ~bwr; cas_lat3_i = ~cl3;
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; trp_wait_i = '0; trc_wait_i = '0;
    cas_lat3_i = 0; bus32_i = 0; burst_wr_i = 0; pwr_wait_i = '0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", 0, {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o, sd_addr_o, busy_o, done_o},
          {C_DESEL, 13'h0, 1'b0, 1'b0});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R8", 0, {sd_cs_n_o, sd_ras_n_o, sd_cas_n_o, sd_we_n_o, sd_addr_o, busy_o, done_o},
          {C_DESEL, 13'h0, 1'b0, 1'b0});
    // R5 directed: no wait, one-cycle wait; R2/R3 extreme gaps
    run_seq(0, 0, 0, 0, 0, 0, -1);
    run_seq(1, 3, 3, 1, 1, 1, -1);
    // R6 every mode-word combination
    for (int m = 0; m < 8; m++) run_seq(0, 1, 2, m[2], m[1], m[0], -1);
    // R9 start while busy
    run_seq(2, 1, 1, 0, 1, 1, 5);
    run_seq(0, 2, 0, 1, 0, 0, 20);
    // constrained random
    for (int i = 0; i < 12; i++)
      run_seq(int'($urandom % 40), int'($urandom % 4), int'($urandom % 4),
              1'($urandom), 1'($urandom), 1'($urandom), -1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule